// File: doc/BRIEF.md
# Timer Compare Channel with Reload

This block is one output-compare channel that sits beside a free-running 31-bit time counter. Software loads a target count, and when the counter reaches it the channel raises a sticky match flag, can assert an interrupt, and drives an output pin. The pin either toggles on every match or gives a single-cycle high pulse. The chosen output mode decides which of these happens.

The compare path has two slots, an active target and a queued target. Software writes the first value, then writes a second value that waits behind it. On each match the queued value moves into the active slot, and the interrupt handler writes the next value. The channel therefore always holds the target after the current one, and a periodic output never misses an edge while software catches up. Software reaches the channel through one write port that selects either the control/status word or the compare value, plus a readback of the control/status word.

Top module: `cmp_channel`

## Requirements
- R1: After reset the control/status readback is 0, the pin is low and the interrupt is low.
- R2: A match happens when the mode is not 0000, an active target is loaded, and `count_in` equals it. On the clock edge that samples the match, the flag (readback bit 7) becomes 1. A control write with bit 7 = 1 clears the flag. A control write with bit 7 = 0 leaves it unchanged.
- R3: `irq` is high exactly when the flag is set and the interrupt enable (control bit 6) is 1.
- R4: With mode 0101 (control bits 5:2), the pin inverts on the edge that samples each match and holds its level otherwise.
- R5: With mode 1111 the pin is high for exactly the one cycle after a match edge and low otherwise.
- R6: With mode 0000 no match occurs and the pin is low. A control write whose mode field is 0000 also forces the pin low and discards both loaded targets.
- R7: Only bits 30:0 of a compare write are kept, so bit 31 has no effect on when the match occurs. The target compares against the 31-bit count, including counts just after the counter wraps.
- R8: A compare write fills the active slot if it is empty, otherwise the queued slot. On a match the queued target becomes active. With no queued target the channel stays idle until the next compare write, which then becomes active.
- R9: A compare write while both slots are full replaces the queued target, and the old queued value never matches.
- R10: The control readback shows the flag in bit 7, the interrupt enable in bit 6, the mode in bits 5:2 and the stored request-enable bit in bit 0. Bit 1 always reads 0.
- R11: If a flag-clearing control write lands on the same edge as a match, the flag ends set.
- R12: A nonzero mode other than 0101 or 1111 still sets the flag on a match, but keeps the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_in | input | 31 | Running time-counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control/status, 1 selects compare |
| wr_data | input | 32 | Write data |
| ctrl_rd | output | 8 | Control/status readback |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
A wrong slot state shows up as a pin edge or flag at the wrong count. An example is a queued target that was never promoted, or a discarded one that survived. The error is visible on the cycle after the count passes the stale or missing target, so the bench tracks a model on every cycle and compares pin, flag and interrupt on each one. Mode or flag errors surface on the next readback of the control word. The bench also counts through a counter wrap, because an unmasked or wrongly widened target only fails there.

// File: rtl/cmp_channel.sv
module cmp_channel #(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_in,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [31:0]   wr_data,
  output logic [7:0]    ctrl_rd,
  output logic          pin_out,
  output logic          irq
);
  localparam logic [3:0] MODE_OFF    = 4'b0000;
  localparam logic [3:0] MODE_TOGGLE = 4'b0101;
  localparam logic [3:0] MODE_PULSE  = 4'b1111;

  logic          flag_q, ie_q, dreq_q, pin_q;
  logic [3:0]    mode_q;
  logic [CW-1:0] act_q, nxt_q, act_d, nxt_d;
  logic          act_v, nxt_v, act_vd, nxt_vd;
  logic          unused_hi;

  wire hit    = (mode_q != MODE_OFF) && act_v && (count_in == act_q);
  wire ctl_wr = wr_en && !wr_sel;
  wire cmp_wr = wr_en && wr_sel;
  wire off_wr = ctl_wr && (wr_data[5:2] == MODE_OFF);

  assign unused_hi = ^wr_data[31:CW];

  always_comb begin
    act_d  = act_q;
    nxt_d  = nxt_q;
    act_vd = act_v;
    nxt_vd = nxt_v;
    if (hit) begin
      if (nxt_v) begin
        act_d  = nxt_q;
        nxt_vd = 1'b0;
      end else begin
        act_vd = 1'b0;
      end
    end
    if (cmp_wr) begin
      if (!act_vd) begin
        act_d  = wr_data[CW-1:0];
        act_vd = 1'b1;
      end else begin
        nxt_d  = wr_data[CW-1:0];
        nxt_vd = 1'b1;
      end
    end
    if (off_wr) begin
      act_vd = 1'b0;
      nxt_vd = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      dreq_q <= 1'b0;
      mode_q <= MODE_OFF;
      pin_q  <= 1'b0;
      act_q  <= '0;
      nxt_q  <= '0;
      act_v  <= 1'b0;
      nxt_v  <= 1'b0;
    end else begin
      flag_q <= hit | (flag_q & ~(ctl_wr & wr_data[7]));
      if (ctl_wr) begin
        ie_q   <= wr_data[6];
        mode_q <= wr_data[5:2];
        dreq_q <= wr_data[0];
      end
      if (off_wr)                    pin_q <= 1'b0;
      else if (mode_q == MODE_TOGGLE) pin_q <= pin_q ^ hit;
      else                           pin_q <= (mode_q == MODE_PULSE) && hit;
      act_q <= act_d;
      nxt_q <= nxt_d;
      act_v <= act_vd;
      nxt_v <= nxt_vd;
    end
  end

  assign ctrl_rd = {flag_q, ie_q, mode_q, 1'b0, dreq_q};
  assign pin_out = pin_q;
  assign irq     = flag_q & ie_q;

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (ctrl_rd == 8'h00 && !pin_out)); // R1
  AST_FLAG_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag_q) |-> $past(mode_q) != MODE_OFF); // R2
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ctrl_rd[6]); // R3
  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_TOGGLE && mode_q != MODE_OFF && !$stable(pin_q)) |-> flag_q); // R4
  AST_PULSE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_PULSE && pin_q) |-> flag_q); // R5
  AST_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == MODE_OFF) |-> !pin_q); // R6
  AST_QUEUE_BEHIND_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) nxt_v |-> act_v); // R8
  AST_BIT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_rd[1]); // R10
endmodule

// File: tb/cmp_channel_test.sv
module cmp_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] cnt = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  ctrl_rd;
  logic        pin_out, irq;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  logic        m_flag, m_ie, m_dreq, m_pin, m_av, m_nv;
  logic [3:0]  m_mode;
  logic [30:0] m_a, m_n;

  always #4 clk = ~clk;

  cmp_channel uut (.clk(clk), .rst_n(rst_n), .count_in(cnt), .wr_en(wr_en), .wr_sel(wr_sel),
                   .wr_data(wr_data), .ctrl_rd(ctrl_rd), .pin_out(pin_out), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_ctrl();
    return {m_flag, m_ie, m_mode, 1'b0, m_dreq};
  endfunction

  task automatic model_reset();
    m_flag = 0; m_ie = 0; m_dreq = 0; m_pin = 0; m_av = 0; m_nv = 0;
    m_mode = 0; m_a = 0; m_n = 0;
  endtask

  task automatic model_step(input logic we, input logic sel, input logic [31:0] wd);
    logic hit, cw, off;
    hit = (m_mode != 4'b0000) && m_av && (cnt == m_a);
    cw  = we && !sel;
    off = cw && (wd[5:2] == 4'b0000);
    if (off) m_pin = 0;
    else if (m_mode == 4'b0101) m_pin = m_pin ^ hit;
    else m_pin = (m_mode == 4'b1111) && hit;
    if (hit) m_flag = 1;
    else if (cw && wd[7]) m_flag = 0;
    if (hit) begin
      if (m_nv) begin m_a = m_n; m_nv = 0; end
      else m_av = 0;
    end
    if (we && sel) begin
      if (!m_av) begin m_a = wd[30:0]; m_av = 1; end
      else begin m_n = wd[30:0]; m_nv = 1; end
    end
    if (cw) begin m_ie = wd[6]; m_mode = wd[5:2]; m_dreq = wd[0]; end
    if (off) begin m_av = 0; m_nv = 0; end
  endtask

  task automatic step(input logic we, input logic sel, input logic [31:0] wd);
    wr_en = we; wr_sel = sel; wr_data = wd;
    model_step(we, sel, wd);
    @(posedge clk); #1;
    wr_en = 0;
    cnt = cnt + 31'd1;
    check("R2 flag/R10 readback", {24'd0, ctrl_rd}, {24'd0, m_ctrl()});
    check("R4 R5 R6 pin", {31'd0, pin_out}, {31'd0, m_pin});
    check("R3 irq", {31'd0, irq}, {31'd0, m_flag & m_ie});
  endtask

  task automatic idle();               step(0, 0, 0);  endtask
  task automatic wctl(input logic [31:0] v); step(1, 0, v); endtask
  task automatic wcmp(input logic [31:0] v); step(1, 1, v); endtask
  task automatic run_to(input logic [30:0] t);
    while (cnt != t) idle();
    idle();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [30:0] a, b, c;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cnt = 31'd100;
    check("R1 ctrl", {24'd0, ctrl_rd}, 32'h0);
    check("R1 pin", {31'd0, pin_out}, 0);
    check("R1 irq", {31'd0, irq}, 0);

    wctl(32'h41);
    check("R10 readback fields", {24'd0, ctrl_rd}, 32'h41);
    wctl(32'h00);

    // toggle with queue, R4 R8
    a = cnt + 6; b = a + 6;
    wcmp({1'b0, a}); wcmp({1'b0, b});
    wctl(32'h54);
    run_to(a);
    check("R4 pin toggled high", {31'd0, pin_out}, 1);
    check("R2 flag set", {31'd0, ctrl_rd[7]}, 1);
    check("R3 irq high", {31'd0, irq}, 1);
    wctl(32'hD4);
    check("R2 flag cleared", {31'd0, ctrl_rd[7]}, 0);
    run_to(b);
    check("R8 queued target matched", {31'd0, pin_out}, 0);
    c = cnt + 4; wcmp({1'b0, c});
    run_to(c);
    check("R8 write after idle goes active", {31'd0, pin_out}, 1);

    // R9 overwrite queued
    wctl(32'hD4);
    a = cnt + 5; b = cnt + 8; c = cnt + 10;
    wcmp({1'b0, a}); wcmp({1'b0, b}); wcmp({1'b0, c});
    run_to(b);
    check("R9 replaced target ignored", {31'd0, pin_out}, 0);
    run_to(c);
    check("R9 replacing target matched", {31'd0, pin_out}, 1);

    // R5 pulse
    wctl(32'hBC);
    a = cnt + 5; wcmp({1'b0, a});
    run_to(a);
    check("R5 pulse high", {31'd0, pin_out}, 1);
    check("R3 irq off when disabled", {31'd0, irq}, 0);
    idle();
    check("R5 pulse one cycle", {31'd0, pin_out}, 0);

    // R11 set wins
    a = cnt + 4; wcmp({1'b0, a});
    while (cnt != a) idle();
    wctl(32'hBC);
    check("R11 match beats clear", {31'd0, ctrl_rd[7]}, 1);

    // R7 bit 31 ignored
    wctl(32'hBC);
    a = cnt + 4; wcmp({1'b1, a});
    run_to(a);
    check("R7 masked target matched", {31'd0, ctrl_rd[7]}, 1);

    // R12 other mode
    wctl(32'h8C);
    a = cnt + 4; wcmp({1'b0, a});
    run_to(a);
    check("R12 flag set", {31'd0, ctrl_rd[7]}, 1);
    check("R12 pin low", {31'd0, pin_out}, 0);

    // R6 off mode
    wctl(32'h00);
    check("R2 zero write keeps flag", {24'd0, ctrl_rd}, 32'h80);
    wctl(32'h80);
    a = cnt + 6; wcmp({1'b0, a});
    run_to(a);
    check("R6 no match when off", {31'd0, ctrl_rd[7]}, 0);
    b = cnt + 8; wcmp({1'b0, b});
    wctl(32'h00); wctl(32'h54);
    run_to(b);
    check("R6 discarded target", {31'd0, ctrl_rd[7]}, 0);
    check("R6 pin low", {31'd0, pin_out}, 0);
    c = cnt + 4; wcmp({1'b0, c});
    run_to(c);
    check("R8 fresh target active", {31'd0, pin_out}, 1);

    // R7 wrap
    cnt = 31'h7FFF_FFFC;
    wcmp(32'h8000_0002);
    run_to(31'd2);
    check("R7 match after wrap", {31'd0, pin_out}, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) begin
        logic [3:0] md;
        case ($urandom % 5)
          0: md = 4'b0101; 1: md = 4'b1111; 2: md = 4'b0000; 3: md = 4'b0011;
          default: md = 4'($urandom);
        endcase
        wctl({24'd0, 1'($urandom), 1'($urandom), md, 1'b0, 1'($urandom)});
      end else if (r < 4) begin
        wcmp({1'($urandom), cnt + 31'($urandom % 40) + 31'd1});
      end else begin
        idle();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule